// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the read/write strobe for one parallel ATA channel that serves two drives. The host loads two timing bytes through a small register port, one per drive, and either two per-drive address-setup bytes or one common setup byte. Each timing byte sets a strobe-active length and a recovery length. Each setup byte sets the delay from address valid to strobe assertion. The setup is chosen when the block is built.

When the block is idle, a transfer request is taken together with a drive select. The block then runs three phases: address setup with the strobe high, strobe active with the strobe low, and recovery with the strobe high. After the last recovery cycle it gives a one-cycle done pulse. The phase lengths are decoded from the selected drive's bytes and are captured when the request is accepted. Register writes made during a transfer therefore act only on later transfers.

In the per-drive arrangement the block itself applies the larger of the two setup values. In the shared arrangement software has to program the slower drive's value into the single register.

Top module: `ata_pio_timer`

## Requirements
- R1: While reset is held and after it is released, strobe_n is 1, xfer_busy is 0 and xfer_done is 0.
- R2: The strobe-active length is timing byte bits 7:4 in clocks. A field value of 0 gives 16 clocks.
- R3: The recovery length is decoded from timing byte bits 3:0. Code 0 gives 16 clocks, code 15 gives 1 clock, and any other code c gives c+1 clocks.
- R4: The address-setup length is decoded from setup byte bits 7:6. Pattern 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5.
- R5: With SHARED_SETUP=0, the setup phase of every transfer lasts the larger of the two decoded setup lengths, whichever drive is selected.
- R6: With SHARED_SETUP=1, the setup byte at address 2 applies to both drives, and writes to address 3 have no effect.
- R7: xfer_drive is sampled when the request is accepted. The transfer uses timing byte 0 (address 0) for drive 0 and timing byte 1 (address 1) for drive 1. xfer_unit shows the sampled drive and does not change while xfer_busy is 1.
- R8: A request is accepted only while xfer_busy is 0, and xfer_busy rises on the next clock. A request made while busy is ignored, with no restart and no second done pulse.
- R9: xfer_done pulses for exactly one cycle, in the cycle right after the last recovery cycle, and xfer_busy falls in that same cycle.
- R10: strobe_n is low only within a transfer, in one unbroken window that lies between the setup phase and at least one recovery cycle.
- R11: A register write made while a transfer is running does not change that transfer's phase lengths. It takes effect on the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0/1 timing drive 0/1, 2/3 setup drive 0/1 (2 is the common byte when shared) |
| cfg_wdata | input | 8 | Register write data |
| xfer_req | input | 1 | Transfer request, taken only when idle |
| xfer_drive | input | 1 | Drive select sampled with the request |
| strobe_n | output | 1 | Active-low read/write strobe |
| xfer_busy | output | 1 | High from acceptance through the last recovery cycle |
| xfer_done | output | 1 | One-cycle pulse after recovery ends |
| xfer_unit | output | 1 | Drive of the current or last transfer |

## Verification
A request that is present at a clock edge while the block is idle raises xfer_busy after that edge. The strobe then falls S cycles later, stays low for A cycles and rises again for R cycles. xfer_done appears in the first cycle after those R cycles, together with the fall of xfer_busy. The bench presents each request on a falling edge and then samples every following falling edge, counting the strobe-high busy cycles before and after the low window and the low cycles themselves. It compares these counts with S, A and R values that it computes arithmetically from the bytes it wrote. It checks the done pulse in the first non-busy cycle and checks that done is gone one cycle later.

// File: rtl/ata_tim_pkg.sv
package ata_tim_pkg;

  localparam int CNT_W = 5;
  localparam int BYTE_W = 8;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  typedef struct packed {
    cnt_t setup;
    cnt_t active;
    cnt_t recov;
  } xfer_cnt_t;

  // strobe-active clocks from the upper nibble; zero stands for sixteen
  function automatic cnt_t act_clocks(input logic [3:0] fld);
    cnt_t r;
    if (fld == 4'd0) r = cnt_t'(16);
    else             r = {1'b0, fld};
    return r;
  endfunction

  // recovery clocks from the lower nibble
  function automatic cnt_t rec_clocks(input logic [3:0] code);
    cnt_t r;
    if (code == 4'd0)       r = cnt_t'(16);
    else if (code == 4'hF)  r = cnt_t'(1);
    else                    r = {1'b0, code} + cnt_t'(1);
    return r;
  endfunction

  // address-setup clocks from the two-bit pattern
  function automatic cnt_t setup_clocks(input logic [1:0] pat);
    cnt_t r;
    case (pat)
      2'b01:   r = cnt_t'(2);
      2'b10:   r = cnt_t'(3);
      2'b00:   r = cnt_t'(4);
      default: r = cnt_t'(5);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ata_tim_regs.sv
module ata_tim_regs
  import ata_tim_pkg::*;
#(
  parameter bit              SHARED_SETUP = 1'b0,
  parameter logic [BYTE_W-1:0] TIM_RST    = '0,
  parameter logic [1:0]      SET_RST      = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] tim0,
  output logic [BYTE_W-1:0] tim1,
  output logic [1:0]        set0_pat,
  output logic [1:0]        set1_pat
);

  localparam logic [1:0] A_TIM0 = 2'd0;
  localparam logic [1:0] A_TIM1 = 2'd1;
  localparam logic [1:0] A_SET0 = 2'd2;
  localparam logic [1:0] A_SET1 = 2'd3;
  localparam int         PAT_HI = BYTE_W - 1;
  localparam int         PAT_LO = BYTE_W - 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      tim0     <= TIM_RST;
      tim1     <= TIM_RST;
      set0_pat <= SET_RST;
    end else if (we) begin
      if (addr == A_TIM0) tim0     <= wdata;
      if (addr == A_TIM1) tim1     <= wdata;
      if (addr == A_SET0) set0_pat <= wdata[PAT_HI:PAT_LO];
    end
  end

  generate
    if (SHARED_SETUP) begin : g_shared
      // one common register serves both drives
      assign set1_pat = set0_pat;
    end else begin : g_per_drive
      logic [1:0] set1_q;
      always_ff @(posedge clk) begin
        if (rst)                            set1_q <= SET_RST;
        else if (we && (addr == A_SET1))    set1_q <= wdata[PAT_HI:PAT_LO];
      end
      assign set1_pat = set1_q;
    end
  endgenerate

endmodule

// File: rtl/ata_tim_decode.sv
module ata_tim_decode
  import ata_tim_pkg::*;
(
  input  logic [BYTE_W-1:0] tim_sel,
  input  logic [1:0]        set0_pat,
  input  logic [1:0]        set1_pat,
  output xfer_cnt_t         cnt
);

  cnt_t s0, s1;

  always_comb begin
    s0         = setup_clocks(set0_pat);
    s1         = setup_clocks(set1_pat);
    cnt.setup  = (s1 > s0) ? s1 : s0;
    cnt.active = act_clocks(tim_sel[BYTE_W-1:BYTE_W-4]);
    cnt.recov  = rec_clocks(tim_sel[3:0]);
  end

endmodule

// File: rtl/ata_tim_seq.sv
module ata_tim_seq
  import ata_tim_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  logic      req_drive,
  input  xfer_cnt_t cnt,
  output logic      strobe_n,
  output logic      busy,
  output logic      done,
  output logic      unit
);

  phase_e ph_q, ph_nx;
  cnt_t   rem_q, rem_nx;
  cnt_t   act_q, act_nx;
  cnt_t   rec_q, rec_nx;
  logic   unit_nx;
  logic   done_nx;

  always_comb begin
    ph_nx   = ph_q;
    rem_nx  = rem_q;
    act_nx  = act_q;
    rec_nx  = rec_q;
    unit_nx = unit;
    done_nx = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (req) begin
          ph_nx   = PH_SETUP;
          rem_nx  = cnt.setup - cnt_t'(1);
          act_nx  = cnt.active;
          rec_nx  = cnt.recov;
          unit_nx = req_drive;
        end
      end
      PH_SETUP: begin
        if (rem_q == '0) begin
          ph_nx  = PH_ACTIVE;
          rem_nx = act_q - cnt_t'(1);
        end else begin
          rem_nx = rem_q - cnt_t'(1);
        end
      end
      PH_ACTIVE: begin
        if (rem_q == '0) begin
          ph_nx  = PH_RECOV;
          rem_nx = rec_q - cnt_t'(1);
        end else begin
          rem_nx = rem_q - cnt_t'(1);
        end
      end
      default: begin
        if (rem_q == '0) begin
          ph_nx   = PH_IDLE;
          done_nx = 1'b1;
        end else begin
          rem_nx = rem_q - cnt_t'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      rem_q    <= '0;
      act_q    <= '0;
      rec_q    <= '0;
      unit     <= 1'b0;
      strobe_n <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      ph_q     <= ph_nx;
      rem_q    <= rem_nx;
      act_q    <= act_nx;
      rec_q    <= rec_nx;
      unit     <= unit_nx;
      strobe_n <= (ph_nx != PH_ACTIVE);
      busy     <= (ph_nx != PH_IDLE);
      done     <= done_nx;
    end
  end

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_tim_pkg::*;
#(
  parameter bit                SHARED_SETUP = 1'b0,
  parameter logic [BYTE_W-1:0] TIM_RST      = '0,
  parameter logic [1:0]        SET_RST      = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              xfer_req,
  input  logic              xfer_drive,
  output logic              strobe_n,
  output logic              xfer_busy,
  output logic              xfer_done,
  output logic              xfer_unit
);

  logic [BYTE_W-1:0] tim0, tim1, tim_sel;
  logic [1:0]        set0_pat, set1_pat;
  xfer_cnt_t         cnt;

  ata_tim_regs #(
    .SHARED_SETUP(SHARED_SETUP),
    .TIM_RST     (TIM_RST),
    .SET_RST     (SET_RST)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .tim0    (tim0),
    .tim1    (tim1),
    .set0_pat(set0_pat),
    .set1_pat(set1_pat)
  );

  assign tim_sel = xfer_drive ? tim1 : tim0;

  ata_tim_decode u_dec (
    .tim_sel (tim_sel),
    .set0_pat(set0_pat),
    .set1_pat(set1_pat),
    .cnt     (cnt)
  );

  ata_tim_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (xfer_req),
    .req_drive(xfer_drive),
    .cnt      (cnt),
    .strobe_n (strobe_n),
    .busy     (xfer_busy),
    .done     (xfer_done),
    .unit     (xfer_unit)
  );

endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk (
  input logic clk,
  input logic rst,
  input logic xfer_req,
  input logic strobe_n,
  input logic xfer_busy,
  input logic xfer_done,
  input logic xfer_unit
);

  logic [4:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)             low_run <= '0;
    else if (!strobe_n)  low_run <= (low_run == 5'd31) ? low_run : low_run + 5'd1;
    else                 low_run <= '0;
  end

  a_r1_idle_strobe_high: assert property (@(posedge clk) disable iff (rst)
    !xfer_busy |-> strobe_n);

  a_r2_active_max: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |-> (low_run < 5'd16));

  a_r7_unit_stable: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && $past(xfer_busy)) |-> $stable(xfer_unit));

  a_r8_accept_idle: assert property (@(posedge clk) disable iff (rst)
    (!xfer_busy && xfer_req) |=> xfer_busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  a_r9_done_with_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_busy) |-> xfer_done);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (!xfer_busy && $past(xfer_busy)));

  a_r10_recovery_follows: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_n) |-> xfer_busy);

endmodule

bind ata_pio_timer ata_pio_timer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .xfer_req (xfer_req),
  .strobe_n (strobe_n),
  .xfer_busy(xfer_busy),
  .xfer_done(xfer_done),
  .xfer_unit(xfer_unit)
);

// File: tb/sim_ata_pio_timer.sv
module sim_ata_pio_timer;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [1:0] xreq;
  logic       xdrv;
  wire  [1:0] stb_n, busy, done, unit;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ata_pio_timer #(.SHARED_SETUP(1'b0)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we[0]), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .xfer_req(xreq[0]), .xfer_drive(xdrv),
    .strobe_n(stb_n[0]), .xfer_busy(busy[0]), .xfer_done(done[0]),
    .xfer_unit(unit[0]));

  ata_pio_timer #(.SHARED_SETUP(1'b1)) u1 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we[1]), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .xfer_req(xreq[1]), .xfer_drive(xdrv),
    .strobe_n(stb_n[1]), .xfer_busy(busy[1]), .xfer_done(done[1]),
    .xfer_unit(unit[1]));

  function automatic int e_act(input logic [3:0] f);
    return (f == 0) ? 16 : int'(f);
  endfunction

  function automatic int e_rec(input logic [3:0] c);
    if (c == 0)  return 16;
    if (c == 15) return 1;
    return int'(c) + 1;
  endfunction

  function automatic int e_set(input logic [1:0] p);
    case (p)
      2'b01:   return 2;
      2'b10:   return 3;
      2'b00:   return 4;
      default: return 5;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_we[w] = 1'b1;
    @(negedge clk);
    cfg_we = 2'b00;
  endtask

  // poke: 0 none, 1 extra request during busy, 2 register write during busy
  task automatic xfer(input int w, input logic d, input int es, input int ea,
                      input int er, input int poke, input logic [1:0] pa,
                      input logic [7:0] pv, input string tag);
    int  s, a, r, ph;
    bit  ended, glitch, drvbad;
    s = 0; a = 0; r = 0; ph = 0; ended = 0; glitch = 0; drvbad = 0;
    @(negedge clk);
    xdrv    = d;
    xreq[w] = 1'b1;
    @(negedge clk);
    xreq = 2'b00;
    for (int i = 0; i < 80; i++) begin
      if (!stb_n[w]) begin
        if (ph == 2) glitch = 1;
        ph = 1;
        a++;
      end else if (busy[w]) begin
        if (ph == 1) ph = 2;
        if (ph == 0) s++;
        else         r++;
      end else begin
        ended = 1;
        break;
      end
      if (unit[w] != d) drvbad = 1;
      if (i == 1 && poke == 1) begin
        xdrv    = ~d;
        xreq[w] = 1'b1;
      end
      if (i == 1 && poke == 2) begin
        cfg_addr  = pa;
        cfg_wdata = pv;
        cfg_we[w] = 1'b1;
      end
      @(negedge clk);
      xreq   = 2'b00;
      cfg_we = 2'b00;
    end
    chk(ended, {tag, " R9 end"}, int'(ended), 1);
    chk(s == es, {tag, " setup"}, s, es);
    chk(a == ea, {tag, " active"}, a, ea);
    chk(r == er, {tag, " recovery"}, r, er);
    chk(!glitch, {tag, " R10 single window"}, int'(glitch), 0);
    chk(!drvbad && unit[w] == d, {tag, " R7 unit"}, int'(unit[w]), int'(d));
    chk(done[w] == 1'b1, {tag, " R9 done pulse"}, int'(done[w]), 1);
    @(negedge clk);
    chk(done[w] == 1'b0 && busy[w] == 1'b0, {tag, " R9/R8 quiet after"},
        int'({done[w], busy[w]}), 0);
  endtask

  task automatic run_all();
    rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; xreq = 0; xdrv = 0;
    repeat (4) @(negedge clk);
    chk(stb_n == 2'b11 && busy == 2'b00 && done == 2'b00, "R1 in reset",
        int'({stb_n, busy, done}), 6'b110000);
    rst = 1'b0;
    @(negedge clk);
    chk(stb_n == 2'b11 && busy == 2'b00 && done == 2'b00, "R1 after reset",
        int'({stb_n, busy, done}), 6'b110000);

    // default bytes: setup pattern 00 -> 4, timing 0x00 -> 16/16
    xfer(0, 1'b0, 4, 16, 16, 0, 2'd0, 8'h00, "R1 defaults");

    // R2 R3 sweep of drive 0 timing byte, setup pattern 01 on both drives
    wr(0, 2'd2, 8'h40);
    wr(0, 2'd3, 8'h40);
    for (int b = 0; b < 256; b++) begin
      wr(0, 2'd0, 8'(b));
      xfer(0, 1'b0, 2, e_act(4'(b >> 4)), e_rec(4'(b)), 0, 2'd0, 8'h00, "R2/R3 drv0");
    end

    // R7 sweep of drive 1 with drive 0 parked on a different byte
    wr(0, 2'd0, 8'h00);
    for (int b = 0; b < 256; b++) begin
      wr(0, 2'd1, 8'(b));
      xfer(0, 1'b1, 2, e_act(4'(b >> 4)), e_rec(4'(b)), 0, 2'd0, 8'h00, "R7 drv1");
    end

    // R4 R5 per-drive setup: the larger of the two applies
    wr(0, 2'd0, 8'h11);
    wr(0, 2'd1, 8'h11);
    for (int p0 = 0; p0 < 4; p0++) begin
      for (int p1 = 0; p1 < 4; p1++) begin
        int sx;
        sx = (e_set(2'(p0)) > e_set(2'(p1))) ? e_set(2'(p0)) : e_set(2'(p1));
        wr(0, 2'd2, {2'(p0), 6'h00});
        wr(0, 2'd3, {2'(p1), 6'h00});
        xfer(0, 1'(p0 & 1), sx, 1, 2, 0, 2'd0, 8'h00, "R4/R5 setup max");
      end
    end

    // R8 request while busy is ignored
    wr(0, 2'd2, 8'h40);
    wr(0, 2'd3, 8'h40);
    wr(0, 2'd0, 8'h23);
    xfer(0, 1'b0, 2, 2, 4, 1, 2'd0, 8'h00, "R8 busy request");

    // R11 write during transfer acts on the next one
    xfer(0, 1'b0, 2, 2, 4, 2, 2'd0, 8'h5A, "R11 during");
    xfer(0, 1'b0, 2, 5, 11, 0, 2'd0, 8'h00, "R11 next");

    // R6 shared setup on u1
    wr(1, 2'd0, 8'h11);
    wr(1, 2'd1, 8'h11);
    for (int p = 0; p < 4; p++) begin
      wr(1, 2'd2, {2'(p), 6'h00});
      wr(1, 2'd3, {2'(p ^ 3), 6'h00});
      xfer(1, 1'b0, e_set(2'(p)), 1, 2, 0, 2'd0, 8'h00, "R6 shared drv0");
      xfer(1, 1'b1, e_set(2'(p)), 1, 2, 0, 2'd0, 8'h00, "R6 shared drv1");
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule